// File: doc/BRIEF.md
# Microprogram Loader with Header-Terminated Copy

This block fills the pageable area of a dual-port control store with a microprogram held in external memory. When it is idle and a start request arrives, it captures the memory word address of the microprogram and the control-store location where the body should go. Its first memory read fetches the header word. The low bits of that word give the word address of the last body word. The loader then reads the body words one by one and writes each into consecutive control-store locations through the write-only port.

The copy ends when the address in the header has been read. The body is never scanned for a terminating code, so configuration data that happens to look like an end-of-operation word cannot stop the load early. After the last write has landed, the loader raises a one-cycle completion pulse and presents the base address it used, so the sequencer may start running the program. A header that points backwards, a base outside the pageable area, or a body that would run past the top of the control store makes the loader raise a one-cycle error pulse instead of the completion pulse.

Memory reads use a valid/ready request channel and a valid-only response channel. Only one read is outstanding at any time, and any number of wait states is tolerated on either channel.

Top module: `ucode_loader`

## Requirements
- R1: After reset, mem_req_valid_o, cs_we_o, done_o, err_o and busy_o are all 0.
- R2: A start request while idle makes the first memory request go to start_addr_i. The end address is taken from bits [MEM_AW-1:0] of the returned header word, and the upper bits are ignored.
- R3: Body reads go to start+1, start+2, … up to the end address, strictly in order. A new request is issued only after the previous response has arrived. A request that is not accepted keeps its valid and address unchanged.
- R4: Body word k (counting from 0) is written to control-store address cs_base_i+k with the returned data. The header word is never written.
- R5: done_o pulses for exactly one cycle, one cycle after the last control-store write. In that same cycle done_base_o equals the captured base and busy_o is 0.
- R6: If the end address is below the start address, err_o pulses once. No body read is made, no write occurs and done_o stays 0.
- R7: If the base is below PAGE_BASE, or base plus body length exceeds 2**CS_AW, err_o pulses once with no body read or write. A body that ends exactly at the top of the store is accepted.
- R8: If the end address equals the start address, the load completes with done_o and no control-store write.
- R9: A start request while busy_o is 1 is ignored. The running copy continues unchanged.
- R10: The written addresses and data do not depend on the number of wait states on the request or response channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-load request from the arbiter |
| start_addr_i | input | MEM_AW | Word address of the microprogram header |
| cs_base_i | input | CS_AW | Control-store address for the first body word |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | MEM_AW | Memory word address to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DATA_W | Read data |
| cs_we_o | output | 1 | Control-store write strobe |
| cs_waddr_o | output | CS_AW | Control-store write address |
| cs_wdata_o | output | DATA_W | Control-store write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse: microprogram resident |
| err_o | output | 1 | One-cycle pulse: load rejected |
| done_base_o | output | CS_AW | Base of the last completed load |

## Verification
A corrupted address register would show at the ports as a request address off the expected sequence. That would be visible at the first body request after the corruption, or as a write to the wrong control-store slot one cycle after the matching response. A wrong end comparison would show either as an extra or missing read, or as done_o arriving at the wrong distance from the last write. The cycle distance between done_o and the last write is checked on every load. The bounds decision is visible within three cycles of the header response, as an err_o pulse together with the absence of any body request.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HREQ  = 3'd1,
        ST_HWAIT = 3'd2,
        ST_CHECK = 3'd3,
        ST_BREQ  = 3'd4,
        ST_BWAIT = 3'd5,
        ST_FIN   = 3'd6
    } ucl_state_e;
endpackage

// File: rtl/ucl_bounds.sv
module ucl_bounds #(
    parameter int MEM_AW    = 22,
    parameter int CS_AW     = 10,
    parameter int PAGE_BASE = 256
) (
    input  logic [MEM_AW-1:0] first_i,
    input  logic [MEM_AW-1:0] last_i,
    input  logic [CS_AW-1:0]  base_i,
    output logic              bad_o,
    output logic              empty_o
);
    localparam int SW = MEM_AW + 2;
    localparam logic [SW-1:0] CS_DEPTH = SW'(1) << CS_AW;
    localparam logic [CS_AW-1:0] PB = CS_AW'(PAGE_BASE);

    logic [SW-1:0] span;
    logic [SW-1:0] reach;
    logic          backwards;

    always_comb begin
        backwards = last_i < first_i;
        span      = SW'(last_i) - SW'(first_i);
        reach     = SW'(base_i) + span;
        empty_o   = last_i == first_i;
        bad_o     = backwards || (base_i < PB) || (reach > CS_DEPTH);
    end
endmodule

// File: rtl/ucl_fsm.sv
module ucl_fsm
    import ucl_pkg::*;
#(
    parameter int MEM_AW    = 22,
    parameter int DATA_W    = 64,
    parameter int CS_AW     = 10,
    parameter int PAGE_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MEM_AW-1:0] start_addr_i,
    input  logic [CS_AW-1:0]  cs_base_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [MEM_AW-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              bad_i,
    input  logic              empty_i,
    output logic [MEM_AW-1:0] first_o,
    output logic [MEM_AW-1:0] last_o,
    output logic [CS_AW-1:0]  base_o,
    output logic              cs_we_o,
    output logic [CS_AW-1:0]  cs_waddr_o,
    output logic [DATA_W-1:0] cs_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CS_AW-1:0]  done_base_o
);
    typedef struct packed {
        ucl_state_e        st;
        logic [MEM_AW-1:0] cur;
        logic [MEM_AW-1:0] first;
        logic [MEM_AW-1:0] last;
        logic [CS_AW-1:0]  base;
        logic [CS_AW-1:0]  wptr;
        logic              we;
        logic [CS_AW-1:0]  waddr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic              err;
        logic [CS_AW-1:0]  dbase;
    } ucl_regs_t;

    ucl_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_HREQ;
                    r_d.cur   = start_addr_i;
                    r_d.first = start_addr_i;
                    r_d.base  = cs_base_i;
                end
            end
            ST_HREQ: begin
                if (mem_req_ready_i) r_d.st = ST_HWAIT;
            end
            ST_HWAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.last = mem_rsp_data_i[MEM_AW-1:0];
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (bad_i) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (empty_i) begin
                    r_d.done  = 1'b1;
                    r_d.dbase = r_q.base;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.cur  = r_q.first + MEM_AW'(1);
                    r_d.wptr = r_q.base;
                    r_d.st   = ST_BREQ;
                end
            end
            ST_BREQ: begin
                if (mem_req_ready_i) r_d.st = ST_BWAIT;
            end
            ST_BWAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.we    = 1'b1;
                    r_d.waddr = r_q.wptr;
                    r_d.wdata = mem_rsp_data_i;
                    r_d.wptr  = r_q.wptr + CS_AW'(1);
                    if (r_q.cur == r_q.last) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.cur = r_q.cur + MEM_AW'(1);
                        r_d.st  = ST_BREQ;
                    end
                end
            end
            ST_FIN: begin
                r_d.done  = 1'b1;
                r_d.dbase = r_q.base;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_valid_o = (r_q.st == ST_HREQ) || (r_q.st == ST_BREQ);
    assign mem_req_addr_o  = r_q.cur;
    assign first_o         = r_q.first;
    assign last_o          = r_q.last;
    assign base_o          = r_q.base;
    assign cs_we_o         = r_q.we;
    assign cs_waddr_o      = r_q.waddr;
    assign cs_wdata_o      = r_q.wdata;
    assign busy_o          = r_q.st != ST_IDLE;
    assign done_o          = r_q.done;
    assign err_o           = r_q.err;
    assign done_base_o     = r_q.dbase;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !err_o); // R5
    AST_DONE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> done_base_o == base_o); // R5
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !cs_we_o && !busy_o); // R6
    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_we_o |-> cs_waddr_o >= CS_AW'(PAGE_BASE)); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !done_o |=> $stable(first_o)); // R9
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader #(
    parameter int MEM_AW    = 22,
    parameter int DATA_W    = 64,
    parameter int CS_AW     = 10,
    parameter int PAGE_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MEM_AW-1:0] start_addr_i,
    input  logic [CS_AW-1:0]  cs_base_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [MEM_AW-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              cs_we_o,
    output logic [CS_AW-1:0]  cs_waddr_o,
    output logic [DATA_W-1:0] cs_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CS_AW-1:0]  done_base_o
);
    logic              bad;
    logic              empty;
    logic [MEM_AW-1:0] first;
    logic [MEM_AW-1:0] last;
    logic [CS_AW-1:0]  base;

    ucl_bounds #(.MEM_AW(MEM_AW), .CS_AW(CS_AW), .PAGE_BASE(PAGE_BASE)) u_bounds (
        .first_i (first),
        .last_i  (last),
        .base_i  (base),
        .bad_o   (bad),
        .empty_o (empty)
    );

    ucl_fsm #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .CS_AW(CS_AW), .PAGE_BASE(PAGE_BASE)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .start_addr_i    (start_addr_i),
        .cs_base_i       (cs_base_i),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .bad_i           (bad),
        .empty_i         (empty),
        .first_o         (first),
        .last_o          (last),
        .base_o          (base),
        .cs_we_o         (cs_we_o),
        .cs_waddr_o      (cs_waddr_o),
        .cs_wdata_o      (cs_wdata_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .err_o           (err_o),
        .done_base_o     (done_base_o)
    );
endmodule

// File: tb/ucode_loader_bench.sv
module ucode_loader_bench;
    localparam int MEM_AW = 22;
    localparam int DATA_W = 64;
    localparam int CS_AW  = 10;
    localparam int PB     = 256;
    localparam int DEPTH  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [MEM_AW-1:0] start_addr_i = '0;
    logic [CS_AW-1:0]  cs_base_i = '0;
    logic mem_req_valid_o;
    logic mem_req_ready_i = 1'b0;
    logic [MEM_AW-1:0] mem_req_addr_o;
    logic mem_rsp_valid_i = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data_i = '0;
    logic cs_we_o;
    logic [CS_AW-1:0] cs_waddr_o;
    logic [DATA_W-1:0] cs_wdata_o;
    logic busy_o, done_o, err_o;
    logic [CS_AW-1:0] done_base_o;

    always #4 clk = ~clk;

    ucode_loader u_ucode_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .cs_base_i(cs_base_i), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .cs_we_o(cs_we_o), .cs_waddr_o(cs_waddr_o), .cs_wdata_o(cs_wdata_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .done_base_o(done_base_o)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rdy_mode = 0;
    logic [MEM_AW-1:0] hdr_addr = '0;
    logic [DATA_W-1:0] hdr_word = '0;

    logic [CS_AW-1:0]  wa [0:63];
    logic [DATA_W-1:0] wd [0:63];
    logic [MEM_AW-1:0] ra [0:127];
    int wcnt = 0, rcnt = 0, done_cnt = 0, err_cnt = 0;
    int last_w_cyc = 0, done_cyc = 0;

    function automatic logic [DATA_W-1:0] body_word(input logic [MEM_AW-1:0] a);
        return {a, 42'h0} ^ (64'(a) * 64'h9E3779B97F4A7C15);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cs_we_o) begin
            if (wcnt < 64) begin
                wa[wcnt] = cs_waddr_o;
                wd[wcnt] = cs_wdata_o;
            end
            wcnt++;
            last_w_cyc = cyc;
        end
        if (done_o) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (err_o) err_cnt++;
    end

    // memory model: one request at a time, random wait states
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            mem_req_ready_i = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
                logic [MEM_AW-1:0] a;
                int dly;
                a = mem_req_addr_o;
                if (rcnt < 128) ra[rcnt] = a;
                rcnt++;
                dly = (rdy_mode == 0) ? 0 : int'($urandom % 4);
                @(negedge clk);
                mem_req_ready_i = 1'b0;
                repeat (dly) @(negedge clk);
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i = (a == hdr_addr) ? hdr_word : body_word(a);
            end
        end
    end

    task automatic run_load(input logic [MEM_AW-1:0] s, input logic [MEM_AW-1:0] e,
                            input int base, input bit poke);
        int n;
        bit ok;
        int t;
        n  = int'(e) - int'(s);
        ok = (e >= s) && (base >= PB) && (base + n <= DEPTH);
        hdr_addr = s;
        hdr_word = {$urandom, 10'($urandom), e};
        wcnt = 0; rcnt = 0; done_cnt = 0; err_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = s; cs_base_i = CS_AW'(base);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; start_addr_i = s + 22'd50; cs_base_i = CS_AW'(300);
            @(negedge clk);
            start_i = 1'b0;
            chk("R9", "busy during poke", 64'(busy_o), 64'd1);
        end
        t = 0;
        while (done_cnt + err_cnt == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        if (ok) begin
            chk("R5", "done pulses", 64'(done_cnt), 64'd1);
            chk("R6", "no err", 64'(err_cnt), 64'd0);
            chk("R4", "write count", 64'(wcnt), 64'(n));
            chk("R3", "read count", 64'(rcnt), 64'(n + 1));
            chk("R2", "header address", 64'(ra[0]), 64'(s));
            for (int k = 0; k < n && k < 63; k++) begin
                chk("R3", "body read address", 64'(ra[k+1]), 64'(s + MEM_AW'(k + 1)));
                chk("R4", "write address", 64'(wa[k]), 64'(base + k));
                chk("R10", "write data", wd[k], body_word(s + MEM_AW'(k + 1)));
            end
            if (n > 0) chk("R5", "done one cycle after last write", 64'(done_cyc), 64'(last_w_cyc + 1));
            else chk("R8", "empty program no write", 64'(wcnt), 64'd0);
            chk("R5", "done base", 64'(done_base_o), 64'(base));
            chk("R5", "idle after done", 64'(busy_o), 64'd0);
        end else begin
            chk("R6", "err pulses", 64'(err_cnt), 64'd1);
            chk("R6", "no done", 64'(done_cnt), 64'd0);
            chk("R7", "no write on reject", 64'(wcnt), 64'd0);
            chk("R7", "header read only", 64'(rcnt), 64'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk("R1", "req valid", 64'(mem_req_valid_o), 64'd0);
        chk("R1", "we", 64'(cs_we_o), 64'd0);
        chk("R1", "done/err/busy", 64'({done_o, err_o, busy_o}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        rdy_mode = 0;
        run_load(22'd100, 22'd108, 256, 1'b0);      // R4 basic
        run_load(22'd500, 22'd500, 400, 1'b0);      // R8 empty
        run_load(22'd900, 22'd899, 400, 1'b0);      // R6 backwards
        run_load(22'd10, 22'd18, 1020, 1'b0);       // R7 overflow
        run_load(22'd10, 22'd18, 1016, 1'b0);       // R7 exact fit
        run_load(22'd10, 22'd12, 255, 1'b0);        // R7 base below page
        rdy_mode = 1;
        run_load(22'd2000, 22'd2030, 600, 1'b1);    // R9 poke while busy, R10 waits
        run_load(22'h3FFFF0, 22'h3FFFFF, 700, 1'b0); // top of memory

        for (int i = 0; i < 24; i++) begin
            logic [MEM_AW-1:0] s;
            int n, b;
            rdy_mode = i % 2;
            s = MEM_AW'($urandom % 4000000);
            n = int'($urandom % 40);
            b = PB + int'($urandom % (DEPTH - PB - n + 1));
            if (i % 6 == 5) b = DEPTH - n + 1 + int'($urandom % 3); // R7 random overflow
            if (b >= DEPTH) b = DEPTH - 1;
            run_load(s, s + MEM_AW'(n), b, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule